// File: doc/BRIEF.md
# Activity-Triggered Power-State Tracker for an Asynchronous Memory

This block is a clocked model of the logic that decides how much power a 256K x 4 asynchronous static memory draws. It samples the memory's chip select, write strobe, 18-bit address and 4-bit data lines once per clock. It compares each sample with the one taken on the previous clock, so it sees select and write-strobe falling edges and changes on any address or data bit.

Each qualifying event moves the block to full power and reloads a hold counter. When the counter runs out with no new event, the block falls back to reduced-active power without any command. The power level therefore follows how often events arrive, not how long the chip stays selected. Whenever the chip is deselected the block reports standby. A one-cycle strobe marks every cycle in which an event is detected.

Top module: `apd_power_ctl`

## Requirements
- R1: While reset is held and on the first cycle after it is released with the chip deselected, `pwr_state` is standby (2'b00) and `wake` is 0.
- R2: A falling edge on `cs_n` (low now, high at the previous clock) raises `wake` in that cycle, and `pwr_state` is full power (2'b10) after the next clock edge.
- R3: A falling edge on `we_n` while `cs_n` is low is an event. A `we_n` falling edge while `cs_n` is high, and any rising edge of `we_n`, are not events.
- R4: A change on any `addr` bit while `cs_n` is low is an event. Address changes while `cs_n` is high are not events.
- R5: A change on any `din` bit is an event only while both `cs_n` and `we_n` are low. Data changes with `we_n` high are not events.
- R6: After the clock edge that samples the last event, `pwr_state` stays full power for exactly `HOLD_CYC` cycles and then becomes reduced-active (2'b01) with no external command.
- R7: Events that arrive less than `HOLD_CYC` cycles apart keep `pwr_state` at full power without a gap.
- R8: If `cs_n` stays low with no events, `pwr_state` stays reduced-active however long the select lasts.
- R9: At the first clock edge that samples `cs_n` high, `pwr_state` becomes standby, whatever the hold count is.
- R10: `pwr_state` only takes the values 2'b00, 2'b01 and 2'b10.
- R11: `wake` is high exactly in the cycles in which at least one qualifying event is present, and never while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Sampled chip select, active low |
| we_n | input | 1 | Sampled write strobe, active low |
| addr | input | ADDR_W | Sampled address lines |
| din | input | DATA_W | Sampled data lines |
| pwr_state | output | 2 | 00 standby, 01 reduced-active, 10 full power |
| wake | output | 1 | High in each cycle in which an event is detected |

## Verification
The assertions assume that every input is stable around each rising clock edge, so each clock sees exactly one sample per line. They also assume that after reset the previous-sample registers stand for a deselected bus with the write strobe high. The bench changes inputs only on falling clock edges and keeps `cs_n` and `we_n` high through reset, so the first select after reset is a true falling edge. Events are spaced either well inside or well outside the hold window, so every expected state transition falls on a known clock edge.

// File: rtl/apd_power_ctl.sv
module apd_power_ctl #(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 4,
  parameter int HOLD_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [1:0]        pwr_state,
  output logic              wake
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [1:0] ST_STBY = 2'b00;
  localparam logic [1:0] ST_LOW  = 2'b01;
  localparam logic [1:0] ST_FULL = 2'b10;

  logic              cs_q, we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] din_q;
  logic [CW-1:0]     cnt;
  logic [1:0]        st;

  wire sel_fall  = cs_q & ~cs_n;
  wire wr_fall   = we_q & ~we_n & ~cs_n;
  wire addr_move = (addr != addr_q) & ~cs_n;
  wire data_move = (din != din_q) & ~cs_n & ~we_n;

  assign wake      = sel_fall | wr_fall | addr_move | data_move;
  assign pwr_state = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      we_q   <= 1'b1;
      addr_q <= '0;
      din_q  <= '0;
      cnt    <= '0;
      st     <= ST_STBY;
    end else begin
      cs_q   <= cs_n;
      we_q   <= we_n;
      addr_q <= addr;
      din_q  <= din;
      if (cs_n) begin
        st  <= ST_STBY;
        cnt <= '0;
      end else if (wake) begin
        st  <= ST_FULL;
        cnt <= CW'(HOLD_CYC - 1);
      end else if (st == ST_FULL) begin
        if (cnt == '0) st <= ST_LOW;
        else cnt <= cnt - 1'b1;
      end
    end
  end

  assert_sel_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q && !cs_n) |=> pwr_state == ST_FULL);

  assert_desel_stby_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> pwr_state == ST_STBY);

  assert_quiet_deselected_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !wake);

  assert_decay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == ST_FULL && cnt == '0 && !wake && !cs_n) |=> pwr_state == ST_LOW);

  assert_low_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == ST_LOW && !wake && !cs_n) |=> $stable(pwr_state));

  assert_event_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && pwr_state == ST_FULL) |=> pwr_state == ST_FULL);

  assert_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state != 2'b11);
endmodule

// File: tb/tb_apd_power_ctl.sv
module tb_apd_power_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        we_n = 1'b1;
  logic [17:0] addr = '0;
  logic [3:0]  din = '0;
  logic [1:0]  pwr_state;
  logic        wake;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  apd_power_ctl #(.ADDR_W(18), .DATA_W(4), .HOLD_CYC(H)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n),
    .addr(addr), .din(din), .pwr_state(pwr_state), .wake(wake)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic settle_wake(input string tag, input int exp);
    #1;
    chk(tag, int'(wake), exp);
  endtask

  task automatic expect_decay(input string tag);
    for (int i = 0; i < H; i++) begin
      tick();
      chk({tag, " full"}, int'(pwr_state), 2);
    end
    tick();
    chk({tag, " reduced"}, int'(pwr_state), 1);
  endtask

  task automatic t_reset();
    chk("R1 state in reset", int'(pwr_state), 0);
    chk("R1 wake in reset", int'(wake), 0);
    tick();
    rst_n = 1'b1;
    tick();
    chk("R1 state after reset", int'(pwr_state), 0);
    chk("R1 wake after reset", int'(wake), 0);
  endtask

  task automatic t_select();
    cs_n = 1'b0;
    settle_wake("R2 wake on select", 1);
    expect_decay("R2 R6 select");
    settle_wake("R11 wake idle", 0);
    for (int i = 0; i < 3 * H; i++) tick();
    chk("R8 long select stays reduced", int'(pwr_state), 1);
    chk("R11 no wake idle", int'(wake), 0);
  endtask

  task automatic t_addr();
    addr = 18'h00001;
    settle_wake("R4 wake on addr", 1);
    for (int r = 0; r < 4; r++) begin
      for (int j = 0; j < H / 2; j++) begin
        tick();
        chk("R7 full between events", int'(pwr_state), 2);
      end
      addr = addr ^ 18'h20000;
      settle_wake("R4 R7 wake on high addr bit", 1);
    end
    expect_decay("R4 R6 addr");
  endtask

  task automatic t_write();
    we_n = 1'b0;
    settle_wake("R3 wake on write strobe", 1);
    expect_decay("R3 write");
    din = 4'h9;
    settle_wake("R5 wake on data during write", 1);
    expect_decay("R5 data");
    we_n = 1'b1;
    settle_wake("R3 strobe rise ignored", 0);
    tick();
    chk("R3 state after strobe rise", int'(pwr_state), 1);
    din = 4'h6;
    settle_wake("R5 data without write ignored", 0);
    tick();
    chk("R5 state after data without write", int'(pwr_state), 1);
  endtask

  task automatic t_deselect();
    addr = 18'h0ABCD;
    settle_wake("R4 wake before deselect", 1);
    tick();
    chk("R4 full before deselect", int'(pwr_state), 2);
    cs_n = 1'b1;
    settle_wake("R11 no wake on deselect", 0);
    tick();
    chk("R9 standby mid hold", int'(pwr_state), 0);
    addr = 18'h15432;
    settle_wake("R4 addr while deselected", 0);
    tick();
    chk("R4 state addr while deselected", int'(pwr_state), 0);
    we_n = 1'b0;
    din = 4'h3;
    settle_wake("R3 R5 strobe and data while deselected", 0);
    tick();
    chk("R9 state stays standby", int'(pwr_state), 0);
    we_n = 1'b1;
    tick();
    cs_n = 1'b0;
    settle_wake("R2 wake on reselect", 1);
    tick();
    chk("R2 full on reselect", int'(pwr_state), 2);
    chk("R11 single cycle strobe", int'(wake), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_select();
    t_addr();
    t_write();
    t_deselect();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule